// File: doc/BRIEF.md
# Floppy Command Busy and Rotational Delay Timer

This block drives the BUSY flag that a floppy controller shows after its command byte is written. It also works out how long a sector transfer must wait before it may start. Every command holds BUSY for a short fixed time. Sector read and write commands instead hold BUSY until the target sector has turned under the head, plus any motor spin-up time still left. That hold never drops below a fixed minimum. When the hold runs out and an inbound data buffer is waiting, the block sends a one-cycle DMA-ready pulse.

A free-running phase counter models the rotating disk. One revolution lasts one fifth of the cycles in a second (300 rpm). The angle of the target sector is the sector index times the revolution period, divided by the number of sectors per track. A serial divider computes this division, and BUSY stays high while the divider works. The block subtracts the current phase from the result and adds one revolution if the difference is negative. For multi-sector reads, the surrounding logic requests timing for the next sector once the previous one has been drained.

Top module: `dsk_busy_timer`

## Requirements
- R1: `cmd_kind` resets to 0 and, one cycle after a command write, holds the class of the upper nibble of `cmd_byte`: 1 for nibbles 0 to 7, 2 for 8 to 11, 4 for 13, and 3 for 12, 14 and 15.
- R2: Any command write other than nibble 13 raises BUSY from the next cycle. For a class-1 or class-3 command, BUSY lasts exactly 20 cycles.
- R3: A write with nibble 13 drops BUSY in the next cycle and cancels both the hold countdown and the divider. It also gives one-cycle pulses on `stat_clr` and `dma_drop`.
- R4: After a class-2 write, BUSY stays high while the divider runs. The transfer hold is loaded at the clock edge that comes NW+1 edges after the write edge, where NW = SEC_W + clog2(REV_CYCLES).
- R5: The transfer hold equals max(XFER_MIN, wait + rot), where `wait` is `motor_wait` sampled at the start. From the load edge on, BUSY stays high for exactly that many cycles.
- R6: rot = floor(sec_idx × REV_CYCLES / sec_per_trk) − phase. Here `phase` is the value of `rev_phase` in the cycle before the load edge. If the difference is negative, REV_CYCLES is added. Both `sec_idx` and `sec_per_trk` are sampled at the start.
- R7: `rev_phase` resets to 0, increases by one each cycle, and wraps from REV_CYCLES−1 back to 0.
- R8: `dma_ready` pulses for one cycle, in the first cycle with BUSY low, when the hold counts out while `buf_in` is high. It does not pulse when the hold ends because of nibble 13, and it does not pulse when a command write or a timing start arrives on the expiry edge.
- R9: `nxt_req` with `nxt_found` high, and no command write in the same cycle, starts a new transfer timing without the 20-cycle hold. `nxt_req` with `nxt_found` low has no effect.
- R10: A command write restarts the hold, overriding any countdown in progress. A non-class-2 write also discards a division in progress.
- R11: If a command write and `nxt_req` arrive in the same cycle, the command write wins and `nxt_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| sec_idx | input | SEC_W | Angular index of the target sector |
| sec_per_trk | input | SEC_W | Sectors per track (nonzero) |
| motor_wait | input | WAIT_W | Remaining motor spin-up cycles |
| buf_in | input | 1 | Inbound data buffer pending |
| nxt_req | input | 1 | Request timing for the next sector |
| nxt_found | input | 1 | Next sector exists |
| busy | output | 1 | BUSY status |
| dma_ready | output | 1 | DMA-ready pulse |
| stat_clr | output | 1 | Status-clear pulse (nibble 13) |
| dma_drop | output | 1 | DMA-ready deassert pulse (nibble 13) |
| cmd_kind | output | 3 | Class of the last command |
| rev_phase | output | clog2(REV_CYCLES) | Revolution phase |

## Verification
Two events can land on the same edge. The first pair is the hold counting out (which would fire `dma_ready`) and a new command write. The second pair is a command write and a next-sector request. The bench waits until its model shows one cycle of hold left, then drives a write, a next-sector request, or both on exactly that edge. A per-cycle model compares BUSY and `dma_ready` to decide which event won: no pulse, and a restarted hold of the expected length.

// File: rtl/dsk_busy_pkg.sv
package dsk_busy_pkg;
  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_STEP  = 3'd1,
    KIND_XFER  = 3'd2,
    KIND_MISC  = 3'd3,
    KIND_ABORT = 3'd4
  } cmd_kind_e;

  function automatic cmd_kind_e kind_of(input logic [3:0] nib);
    if (!nib[3])            return KIND_STEP;
    else if (!nib[2])       return KIND_XFER;
    else if (nib == 4'hD)   return KIND_ABORT;
    else                    return KIND_MISC;
  endfunction
endpackage

// File: rtl/dsk_rev_phase.sv
module dsk_rev_phase #(
  parameter int REV = 2000,
  parameter int PW  = $clog2(REV)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] LAST = PW'(REV - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end
endmodule

// File: rtl/dsk_seq_div.sv
module dsk_seq_div #(
  parameter int NW = 16,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [NW-1:0] numer,
  input  logic [DW-1:0] denom,
  output logic          active,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);

  logic          run;
  logic [CW-1:0] cnt;
  logic [NW-1:0] q;
  logic [DW-1:0] rem, dq;
  logic [DW:0]   shifted;
  logic          fits;

  assign shifted = {rem, q[NW-1]};
  assign fits    = shifted >= {1'b0, dq};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; cnt <= '0; q <= '0; rem <= '0; dq <= '0;
    end else if (abort) begin
      run <= 1'b0;
    end else if (start) begin
      run <= 1'b1; cnt <= CW'(NW); q <= numer; rem <= '0; dq <= denom;
    end else if (run) begin
      if (cnt != '0) begin
        rem <= fits ? DW'(shifted - {1'b0, dq}) : shifted[DW-1:0];
        q   <= {q[NW-2:0], fits};
        cnt <= cnt - 1'b1;
      end else begin
        run <= 1'b0;
      end
    end
  end

  assign active = run;
  assign done   = run && (cnt == '0);
  assign quot   = q;
endmodule

// File: rtl/dsk_hold_timer.sv
module dsk_hold_timer #(
  parameter int TW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          active,
  output logic          last
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = cnt != '0;
  assign last   = cnt == TW'(1);
endmodule

// File: rtl/dsk_busy_timer.sv
module dsk_busy_timer
  import dsk_busy_pkg::*;
#(
  parameter int CLK_PER_SEC = 10000,
  parameter int SEC_W       = 5,
  parameter int WAIT_W      = 12,
  parameter int CMD_HOLD    = 20,
  parameter int XFER_MIN    = 500,
  parameter int REV_CYCLES  = CLK_PER_SEC / 5,
  parameter int PH_W        = $clog2(REV_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_byte,
  input  logic [SEC_W-1:0]  sec_idx,
  input  logic [SEC_W-1:0]  sec_per_trk,
  input  logic [WAIT_W-1:0] motor_wait,
  input  logic              buf_in,
  input  logic              nxt_req,
  input  logic              nxt_found,
  output logic              busy,
  output logic              dma_ready,
  output logic              stat_clr,
  output logic              dma_drop,
  output logic [2:0]        cmd_kind,
  output logic [PH_W-1:0]   rev_phase
);
  localparam int NW = SEC_W + PH_W;
  localparam int TW = ((NW > WAIT_W) ? NW : WAIT_W) + 2;

  function automatic logic [TW-1:0] xfer_time(input logic [NW-1:0] q,
                                              input logic [PH_W-1:0] ph,
                                              input logic [WAIT_W-1:0] mw);
    logic [TW-1:0] rot, sum;
    if (TW'(q) >= TW'(ph)) rot = TW'(q) - TW'(ph);
    else                   rot = TW'(q) + TW'(REV_CYCLES) - TW'(ph);
    sum = rot + TW'(mw);
    return (sum < TW'(XFER_MIN)) ? TW'(XFER_MIN) : sum;
  endfunction

  cmd_kind_e          kind_now;
  logic               fi_hit, div_start, div_abort, div_active, div_done;
  logic               hold_load, hold_active, hold_last, expire;
  logic [NW-1:0]      quot;
  logic [WAIT_W-1:0]  wait_q;
  logic [TW-1:0]      load_val;

  assign kind_now  = kind_of(cmd_byte[7:4]);
  assign fi_hit    = cmd_we && (kind_now == KIND_ABORT);
  assign div_start = (cmd_we && kind_now == KIND_XFER) ||
                     (!cmd_we && nxt_req && nxt_found);
  assign div_abort = cmd_we && (kind_now != KIND_XFER);
  assign hold_load = (cmd_we && !fi_hit) || (div_done && !div_start);
  assign load_val  = cmd_we ? TW'(CMD_HOLD) : xfer_time(quot, rev_phase, wait_q);
  assign expire    = hold_last && !div_active && !cmd_we && !div_start;

  dsk_rev_phase #(.REV(REV_CYCLES), .PW(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(rev_phase));

  dsk_seq_div #(.NW(NW), .DW(SEC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .abort(div_abort),
    .numer(NW'(sec_idx) * NW'(REV_CYCLES)), .denom(sec_per_trk),
    .active(div_active), .done(div_done), .quot(quot));

  dsk_hold_timer #(.TW(TW)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(fi_hit), .load(hold_load),
    .load_val(load_val), .active(hold_active), .last(hold_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= '0; dma_ready <= 1'b0; stat_clr <= 1'b0; dma_drop <= 1'b0;
      cmd_kind <= KIND_NONE;
    end else begin
      if (div_start) wait_q <= motor_wait;
      if (cmd_we)    cmd_kind <= kind_now;
      dma_ready <= expire && buf_in;
      stat_clr  <= fi_hit;
      dma_drop  <= fi_hit;
    end
  end

  assign busy = hold_active || div_active;
endmodule

// File: rtl/dsk_busy_timer_chk.sv
module dsk_busy_timer_chk #(
  parameter int REV_CYCLES = 2000,
  parameter int PH_W       = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_we,
  input logic [7:0]      cmd_byte,
  input logic            busy,
  input logic            dma_ready,
  input logic            stat_clr,
  input logic            dma_drop,
  input logic            div_active,
  input logic [PH_W-1:0] rev_phase
);
  // R3
  fi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte[7:4] == 4'hD) |=> (!busy && stat_clr && dma_drop));
  // R2
  cmd_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte[7:4] != 4'hD) |=> busy);
  // R8
  dma_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ready |-> (!busy && !stat_clr));
  // R8
  dma_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ready |-> $past(busy));
  // R7
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_phase == PH_W'(REV_CYCLES - 1)) |=> (rev_phase == '0));
  // R7
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev_phase < PH_W'(REV_CYCLES));
  // R4
  div_holds_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_active |-> busy);
endmodule

bind dsk_busy_timer dsk_busy_timer_chk #(.REV_CYCLES(REV_CYCLES), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte), .busy(busy),
  .dma_ready(dma_ready), .stat_clr(stat_clr), .dma_drop(dma_drop),
  .div_active(div_active), .rev_phase(rev_phase));

// File: tb/dsk_busy_timer_test.sv
`timescale 1ns/1ps
module dsk_busy_timer_test;
  localparam int REV  = 2000;
  localparam int PH_W = 11;
  localparam int NW   = 5 + PH_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [4:0] sec_idx = 5'd0, sec_per_trk = 5'd16;
  logic [11:0] motor_wait = 12'd0;
  logic buf_in = 1'b0, nxt_req = 1'b0, nxt_found = 1'b0;
  logic busy, dma_ready, stat_clr, dma_drop;
  logic [2:0] cmd_kind;
  logic [PH_W-1:0] rev_phase;

  always #4 clk = ~clk;

  dsk_busy_timer uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .sec_idx(sec_idx), .sec_per_trk(sec_per_trk), .motor_wait(motor_wait),
    .buf_in(buf_in), .nxt_req(nxt_req), .nxt_found(nxt_found),
    .busy(busy), .dma_ready(dma_ready), .stat_clr(stat_clr), .dma_drop(dma_drop),
    .cmd_kind(cmd_kind), .rev_phase(rev_phase));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_phase, m_timer, m_left, m_mw, m_sec, m_spt, m_kind;
  bit m_dma, m_sclr, m_drop;
  int code, ph_b, qv, rot;
  bit st, ex;

  function automatic int kind_ref(input int c);
    if (c >= 8 && c <= 11) return 2;
    if (c == 13) return 4;
    if (c >= 12) return 3;
    return 1;
  endfunction

  // R5 and R6: hold length from sector angle, phase and motor wait
  function automatic int hold_ref(input int sec, input int spt, input int ph, input int mw);
    int q, r;
    q = (sec * REV) / spt;
    r = q - ph;
    if (r < 0) r += REV;
    r += mw;
    return (r < 500) ? 500 : r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_timer = 0; m_left = 0; m_mw = 0; m_sec = 0; m_spt = 1;
      m_kind = 0; m_dma = 0; m_sclr = 0; m_drop = 0;
    end else begin
      ph_b = m_phase;
      code = int'(cmd_byte[7:4]);
      st = (cmd_we && code >= 8 && code <= 11) || (!cmd_we && nxt_req && nxt_found);
      ex = (m_timer == 1) && (m_left == 0) && !cmd_we && !st;
      m_dma  = ex && buf_in;
      m_sclr = cmd_we && code == 13;
      m_drop = m_sclr;
      if (cmd_we) m_kind = kind_ref(code);
      if (cmd_we && code == 13) begin
        m_timer = 0; m_left = 0;
      end else if (cmd_we) begin
        m_timer = 20;
        m_left = st ? NW + 1 : 0;
      end else if (st) begin
        if (m_timer > 0) m_timer--;
        m_left = NW + 1;
      end else if (m_left == 1) begin
        m_timer = hold_ref(m_sec, m_spt, ph_b, m_mw);
        m_left = 0;
      end else begin
        if (m_timer > 0) m_timer--;
        if (m_left > 0) m_left--;
      end
      if (st) begin
        m_mw = int'(motor_wait); m_sec = int'(sec_idx); m_spt = int'(sec_per_trk);
      end
      m_phase = (m_phase + 1) % REV;
    end
  end

  task automatic cmp(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp("R5 busy", int'(busy), int'(m_timer > 0 || m_left > 0));
    cmp("R8 dma_ready", int'(dma_ready), int'(m_dma));
    cmp("R3 stat_clr", int'(stat_clr), int'(m_sclr));
    cmp("R3 dma_drop", int'(dma_drop), int'(m_drop));
    cmp("R1 cmd_kind", int'(cmd_kind), m_kind);
    cmp("R7 rev_phase", int'(rev_phase), m_phase);
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 190000) begin
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  task automatic issue(input logic [7:0] b);
    @(negedge clk); cmd_byte = b; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic settle();
    while (m_timer > 0 || m_left > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic to_last();
    @(negedge clk);
    while (!(m_timer == 1 && m_left == 0)) @(negedge clk);
  endtask

  int seed = 7;
  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state and phase counting
    cmp("R1 reset cmd_kind", int'(cmd_kind), 0);
    cmp("R5 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 and R2: every nibble class, fixed 20-cycle hold
    for (int c = 0; c < 16; c++) begin
      issue(8'(c << 4));
      settle();
    end
    // R4, R5, R6: sector timings, inbound buffer pending so R8 fires
    buf_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      seed = (seed * 1103 + 12345) % 65536;
      sec_per_trk = 5'(1 + seed % 31);
      sec_idx = 5'((seed / 31) % int'(sec_per_trk));
      motor_wait = 12'((i % 3 == 0) ? (seed % 1200) : 0);
      repeat (seed % 700) @(negedge clk);
      issue(8'h80 | 8'(i << 4 & 8'h30));
      settle();
    end
    motor_wait = 12'd0;
    // R8: pulse suppressed without pending buffer
    buf_in = 1'b0; issue(8'h90); settle();
    buf_in = 1'b1;
    // R3: force interrupt during a sector hold and during the division
    sec_idx = 5'd9; sec_per_trk = 5'd18;
    issue(8'hA0); repeat (100) @(negedge clk); issue(8'hD0); settle();
    issue(8'hB0); repeat (5) @(negedge clk); issue(8'hD8); settle();
    // R10: class-1 write overrides a sector hold and a running division
    issue(8'h80); repeat (200) @(negedge clk); issue(8'h10); settle();
    issue(8'h80); repeat (3) @(negedge clk); issue(8'hC0); settle();
    // R10: write on the exact expiry edge, no dma pulse
    issue(8'h20); to_last(); cmd_byte = 8'h30; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0; settle();
    // R9: next-sector request found and not found
    sec_idx = 5'd3; sec_per_trk = 5'd16;
    nxt_req = 1'b1; nxt_found = 1'b0; @(negedge clk); nxt_req = 1'b0;
    repeat (5) @(negedge clk);
    nxt_req = 1'b1; nxt_found = 1'b1; @(negedge clk); nxt_req = 1'b0; settle();
    // R9: next-sector request on the expiry edge keeps busy
    issue(8'h00); to_last(); sec_idx = 5'd15;
    nxt_req = 1'b1; @(negedge clk); nxt_req = 1'b0; settle();
    // R11: command write and next-sector request together
    issue(8'h80); to_last(); cmd_byte = 8'h40; cmd_we = 1'b1; nxt_req = 1'b1;
    @(negedge clk); cmd_we = 1'b0; nxt_req = 1'b0; settle();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule